// File: doc/BRIEF.md
# Motor Fault Supervisor with Tachometer

This block watches a three-phase brushless motor drive for fault conditions and chooses the protective action for each. It takes the three Hall-sensor lines, an undervoltage flag for the gate supply, an over-temperature flag, one short-to-ground detect per phase, a reset input and a commutation strobe. It produces a fault flag, a coast request that turns off all six power switches, a request that turns off only the three high-side switches, and a tachometer pulse.

The Hall lines are asynchronous to `clk`. Each line passes through a two-flop synchronizer and then an agreement filter before it is used. The filtered code drives both the invalid-code check and the tachometer. A short to ground is the only fault that is held in a latch. That latch clears on the next commutation or on reset. Undervoltage, over-temperature and an invalid Hall code are live conditions: they request coast only while they are present.

Top module: `motor_fault_supervisor`

## Requirements
- R1: `fault_o` is 1 one cycle after undervoltage, over-temperature or an invalid filtered Hall code is present, and one cycle after the short latch is set. It is 0 once none of these holds.
- R2: `coast_o` is 1 one cycle after `uv_i` or `ot_i` is 1. It follows these inputs live and returns to 0 one cycle after they and any invalid code are gone. A short to ground never raises `coast_o`.
- R3: Hall code 3'b000 and Hall code 3'b111 (bit 0 = `hall_i[0]`) are invalid and raise `coast_o` and `fault_o`. The other six codes are valid.
- R4: Any `gnd_short_i` bit that is 1 for a single cycle sets the short latch. `hs_off_o` is 1 from the next cycle and stays 1 after the detect input drops.
- R5: The short latch is cleared by `commut_i`, by `reset_i` or by `rst_n` low, and `hs_off_o` reads 0 the next cycle. A clear in the same cycle as a set wins over the set.
- R6: A Hall line level is taken into the filtered code only after it has been seen on 4 consecutive synchronized samples. A level that lasts 3 cycles or fewer at the input has no effect on any output.
- R7: `tach_o` gives exactly one pulse, one cycle wide, for each change of the filtered Hall code. Several bits that change together give one pulse. The pulse is high in the 7th cycle after the first clock edge that samples the new input level.
- R8: While `rst_n` is low, all outputs are 0. The filtered code starts at 3'b111, so `fault_o` and `coast_o` are 1 from the first cycle after reset until a valid code has passed the filter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hall_i | input | 3 | Raw Hall-sensor lines, asynchronous |
| uv_i | input | 1 | Gate-supply undervoltage flag |
| ot_i | input | 1 | Over-temperature flag |
| gnd_short_i | input | 3 | Per-phase short-to-ground detects |
| reset_i | input | 1 | Reset input; while it is 1 the short latch is held clear |
| commut_i | input | 1 | Commutation strobe; clears the short latch |
| fault_o | output | 1 | Registered fault flag, active high |
| coast_o | output | 1 | Request to turn off all six switches |
| hs_off_o | output | 1 | Request to turn off the three high-side switches |
| tach_o | output | 1 | One-cycle pulse for each filtered Hall change |

## Verification
There are two ways a wrong short latch shows up. A latch that fails to clear leaves `hs_off_o` high in the cycle after a commutation strobe. A latch that fails to hold drops `hs_off_o` while no clear has been given. Either one is visible within one clock. A wrong filter history or a wrong stored Hall code changes the number of tachometer pulses within about seven cycles of a Hall change. It can also produce a spurious or missing coast request for the code now present. For that reason the bench counts pulses and checks the live fault outputs at the end of every held Hall pattern.

// File: rtl/motor_fault_supervisor.sv
module motor_fault_supervisor #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_i,
  input  logic       uv_i,
  input  logic       ot_i,
  input  logic [2:0] gnd_short_i,
  input  logic       reset_i,
  input  logic       commut_i,
  output logic       fault_o,
  output logic       coast_o,
  output logic       hs_off_o,
  output logic       tach_o
);
  localparam int SW = SYNC_STAGES * 3;

  logic [SW-1:0] sync_q;
  logic [2:0]    hall_s;
  logic [2:0]    hall_nxt;
  logic [2:0]    hall_f;
  logic          hall_bad;
  logic          short_lat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SW-4:0], hall_i};

  assign hall_s = sync_q[SW-1 -: 3];

  for (genvar b = 0; b < 3; b++) begin : g_filt
    logic [FILT_LEN-1:0] hist;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) hist <= '1;
      else        hist <= {hist[FILT_LEN-2:0], hall_s[b]};
    assign hall_nxt[b] = (&hist) ? 1'b1 : (~|hist) ? 1'b0 : hall_f[b];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hall_f <= 3'b111;
      tach_o <= 1'b0;
    end else begin
      hall_f <= hall_nxt;
      tach_o <= (hall_nxt != hall_f);
    end

  assign hall_bad = (hall_f == 3'b000) || (hall_f == 3'b111);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 short_lat <= 1'b0;
    else if (commut_i || reset_i) short_lat <= 1'b0;
    else if (|gnd_short_i)      short_lat <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      coast_o <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      coast_o <= uv_i | ot_i | hall_bad;
      fault_o <= uv_i | ot_i | hall_bad | short_lat;
    end

  assign hs_off_o = short_lat;
endmodule

module motor_fault_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       uv_i,
  input logic       ot_i,
  input logic       reset_i,
  input logic       commut_i,
  input logic [2:0] hall_f,
  input logic       fault_o,
  input logic       coast_o,
  input logic       hs_off_o,
  input logic       tach_o
);
  AST_COAST_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_i || ot_i) |=> coast_o); // R2
  AST_COAST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_i && !ot_i && hall_f != 3'b000 && hall_f != 3'b111) |=> !coast_o); // R3
  AST_FAULT_COVER: assert property (@(posedge clk) disable iff (!rst_n)
    coast_o |-> fault_o); // R1
  AST_FAULT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    hs_off_o |=> fault_o); // R1
  AST_SHORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_off_o && !commut_i && !reset_i) |=> hs_off_o); // R4
  AST_SHORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (commut_i || reset_i) |=> !hs_off_o); // R5
  AST_TACH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    tach_o |-> (hall_f != $past(hall_f))); // R7
endmodule

bind motor_fault_supervisor motor_fault_supervisor_chk i_chk (
  .clk(clk), .rst_n(rst_n), .uv_i(uv_i), .ot_i(ot_i), .reset_i(reset_i),
  .commut_i(commut_i), .hall_f(hall_f), .fault_o(fault_o), .coast_o(coast_o),
  .hs_off_o(hs_off_o), .tach_o(tach_o)
);

// File: tb/test_motor_fault_supervisor.sv
`timescale 1ns/1ps
module test_motor_fault_supervisor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall_i = 3'b101;
  logic       uv_i = 1'b0, ot_i = 1'b0, reset_i = 1'b0, commut_i = 1'b0;
  logic [2:0] gnd_short_i = 3'b000;
  logic       fault_o, coast_o, hs_off_o, tach_o;
  int checks = 0, failures = 0, tach_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  motor_fault_supervisor i_motor_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .hall_i(hall_i), .uv_i(uv_i), .ot_i(ot_i),
    .gnd_short_i(gnd_short_i), .reset_i(reset_i), .commut_i(commut_i),
    .fault_o(fault_o), .coast_o(coast_o), .hs_off_o(hs_off_o), .tach_o(tach_o));

  always @(posedge clk) if (tach_o) tach_cnt <= tach_cnt + 1;

  function automatic bit code_bad(input logic [2:0] c);
    return (c == 3'b000) || (c == 3'b111);
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base;
    bit seen;
    logic [2:0] prev, code;
    bit exp_short, u, o, g, cm;
    void'($urandom(32'h5EED_0042));
    nc(5);
    chk(fault_o, 0, "R8 reset fault"); chk(coast_o, 0, "R8 reset coast");
    chk(hs_off_o, 0, "R8 reset hs_off"); chk(tach_o, 0, "R8 reset tach");
    rst_n = 1'b1;
    nc(1);
    chk(coast_o, 1, "R8 start coast"); chk(fault_o, 1, "R8 start fault");
    nc(12);
    chk(coast_o, 0, "R8 settled coast"); chk(fault_o, 0, "R8 settled fault");
    chk(tach_cnt, 1, "R7 first filtered change");

    // exact tach latency
    base = tach_cnt;
    hall_i = 3'b100;
    nc(6); chk(tach_o, 0, "R7 tach before 7th");
    nc(1); chk(tach_o, 1, "R7 tach at 7th");
    nc(1); chk(tach_o, 0, "R7 tach one cycle");
    nc(4); chk(tach_cnt - base, 1, "R7 one pulse for change");

    // 3-cycle glitch to an invalid code is ignored
    base = tach_cnt; seen = 0;
    hall_i = 3'b000; nc(3); hall_i = 3'b100;
    for (int i = 0; i < 12; i++) begin nc(1); if (coast_o || fault_o) seen = 1; end
    chk(seen, 0, "R6 short glitch no fault");
    chk(tach_cnt - base, 0, "R6 short glitch no tach");

    // 4-cycle pulse is accepted
    base = tach_cnt;
    hall_i = 3'b110; nc(4); hall_i = 3'b100;
    nc(14);
    chk(tach_cnt - base, 2, "R6 four-cycle level accepted");

    // invalid code held
    hall_i = 3'b111; nc(10);
    chk(coast_o, 1, "R3 code 111 coast"); chk(fault_o, 1, "R3 code 111 fault");
    hall_i = 3'b000; nc(10);
    chk(coast_o, 1, "R3 code 000 coast");
    hall_i = 3'b100; nc(10);
    chk(coast_o, 0, "R3 valid code no coast");

    // undervoltage and thermal
    uv_i = 1'b1; nc(1);
    chk(coast_o, 1, "R2 uv coast"); chk(fault_o, 1, "R1 uv fault");
    uv_i = 1'b0; nc(1);
    chk(coast_o, 0, "R2 uv live drop"); chk(fault_o, 0, "R1 uv fault drop");
    ot_i = 1'b1; nc(1);
    chk(coast_o, 1, "R2 ot coast");
    ot_i = 1'b0; nc(1);
    chk(coast_o, 0, "R2 ot live drop");

    // short to ground latch
    gnd_short_i = 3'b010; nc(1); gnd_short_i = 3'b000;
    chk(hs_off_o, 1, "R4 short latched"); chk(coast_o, 0, "R2 short no coast");
    nc(1); chk(fault_o, 1, "R1 short fault");
    nc(5); chk(hs_off_o, 1, "R4 latch holds");
    commut_i = 1'b1; nc(1); commut_i = 1'b0;
    chk(hs_off_o, 0, "R5 commutation clears");
    nc(1); chk(fault_o, 0, "R1 fault after clear");
    gnd_short_i = 3'b001; nc(1); gnd_short_i = 3'b000;
    reset_i = 1'b1; nc(1); reset_i = 1'b0;
    chk(hs_off_o, 0, "R5 reset input clears");
    gnd_short_i = 3'b100; commut_i = 1'b1; nc(1);
    gnd_short_i = 3'b000; commut_i = 1'b0;
    chk(hs_off_o, 0, "R5 clear beats set");
    gnd_short_i = 3'b100; nc(1); gnd_short_i = 3'b000;
    rst_n = 1'b0; nc(1);
    chk(hs_off_o, 0, "R5 power-on reset clears");
    rst_n = 1'b1; nc(12);

    // random phase
    prev = 3'b100; exp_short = 0;
    for (int it = 0; it < 150; it++) begin
      code = 3'($urandom % 8);
      u = ($urandom % 8) == 0;
      o = ($urandom % 8) == 0;
      g = ($urandom % 5) == 0;
      cm = ($urandom % 4) == 0;
      base = tach_cnt;
      hall_i = code; uv_i = u; ot_i = o; commut_i = cm;
      gnd_short_i = g ? 3'(1 << ($urandom % 3)) : 3'b000;
      if (cm) exp_short = 0; else if (g) exp_short = 1;
      nc(1); gnd_short_i = 3'b000; commut_i = 1'b0;
      nc(11);
      chk(coast_o, int'(u | o | code_bad(code)), "R2 random coast");
      chk(fault_o, int'(u | o | code_bad(code) | exp_short), "R1 random fault");
      chk(hs_off_o, int'(exp_short), "R4 random latch");
      chk(tach_cnt - base, int'(code != prev), "R7 random tach count");
      prev = code;
    end
    uv_i = 1'b0; ot_i = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(1_000_000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule